// File: doc/BRIEF.md
# Transmit Interpolator-to-DAC Router

This block sits between two transmit interpolator channels and four DAC outputs. Each interpolator channel delivers a complex sample, an I part and a Q part. That gives four source components. A routing register decides which component drives each DAC. Any component may feed several DACs at the same time. A DAC whose routing field is not enabled is driven with zero, and its enable output is low.

The routing register is loaded through a plain write port and can be read back at all times. The DAC outputs are registered. They take a new value only on the clock edge that sees the sample strobe, so a routing change takes effect at the next strobe. A source code outside the defined set is treated as a fault. The affected DAC carries zero and an error flag is raised.

Top module: `tx_dac_router`

## Requirements
- R1: After reset the routing register reads 0x00000000, every DAC enable output is low, every DAC data output is zero and the error flag is low.
- R2: A clock edge with `cfg_we` high loads bits [15:0] of `cfg_wdata` into the routing register, and `cfg_rdata` shows the new value after that edge. Without `cfg_we` the register keeps its value.
- R3: Bits [31:16] of `cfg_wdata` are ignored, and bits [31:16] of `cfg_rdata` always read zero.
- R4: The routing field of DAC k is register bits [4k+3:4k], with DAC0 in the least significant nibble. Bit 3 of a field enables the DAC and bits [2:0] hold its source code.
- R5: Source code 0 selects channel 0 I, code 1 selects channel 0 Q, code 2 selects channel 1 I and code 3 selects channel 1 Q.
- R6: A DAC whose enable bit is clear drives zero data and a low `dac_en` bit, whatever its source code is.
- R7: Several enabled DACs given the same source code all carry that same component.
- R8: An enabled DAC with a reserved source code (4 to 7) drives zero data with `dac_en` high, and `route_err` goes high. When no enabled DAC holds a reserved code, `route_err` is low.
- R9: Data, enable and error outputs change only on the clock edge where `smp_stb` is high, one clock after the strobe is applied. Changes to the inputs or the register between strobes do not reach the outputs.
- R10: A reserved source code in a disabled DAC field does not raise `route_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Routing register write enable |
| cfg_wdata | input | 32 | Routing register write data |
| cfg_rdata | output | 32 | Routing register read data |
| smp_stb | input | 1 | Sample strobe; outputs update on the edge where it is high |
| ch_i | input | 32 | I components, channel 0 in bits [15:0], channel 1 in bits [31:16] |
| ch_q | input | 32 | Q components, channel 0 in bits [15:0], channel 1 in bits [31:16] |
| dac_data | output | 64 | DAC samples, DAC k in bits [16k+15:16k] |
| dac_en | output | 4 | Per-DAC enable, bit k for DAC k |
| route_err | output | 1 | An enabled DAC held a reserved source code at the last strobe |

## Verification
The assertions assume that `smp_stb`, `cfg_we` and the data inputs are driven synchronously and are never unknown once reset is released. They also assume that a write and a strobe in the same cycle route with the value the register held before that edge. The bench changes inputs only on the falling clock edge. It drives known values at all times and always places a write and a strobe in different cycles, so every check sees a routing value that has settled. Reserved codes are applied on purpose, in both enabled and disabled fields, so the error path is exercised.

// File: rtl/tx_route_pkg.sv
package tx_route_pkg;
   localparam int FIELD_W  = 4;
   localparam int CODE_W   = 3;
   localparam int EN_BIT   = 3;

   typedef struct packed {
      logic              en;
      logic [CODE_W-1:0] code;
   } route_field_t;
endpackage

// File: rtl/tx_route_cfg.sv
module tx_route_cfg #(
   parameter int CFG_W   = 32,
   parameter int ROUTE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output logic [ROUTE_W-1:0] route
);
   localparam logic [CFG_W-1:0] KEEP_MASK = CFG_W'((64'd1 << ROUTE_W) - 64'd1);

   if (ROUTE_W > CFG_W) begin : g_bad_width
      $error("routing field wider than the register");
   end

   logic [ROUTE_W-1:0] route_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  route_q <= '0;
      else if (we) route_q <= wdata[ROUTE_W-1:0];
   end

   assign route = route_q;
   assign rdata = CFG_W'(route_q);

   // R2
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata == ($past(wdata) & KEEP_MASK));

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(rdata));

   // R3
   cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~KEEP_MASK) == '0);
endmodule

// File: rtl/tx_route_lane.sv
module tx_route_lane
   import tx_route_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int NUM_SRC  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        stb,
   input  route_field_t                field,
   input  logic [NUM_SRC*SAMPLE_W-1:0] srcs,
   output logic [SAMPLE_W-1:0]         data,
   output logic                        en,
   output logic                        err
);
   if (NUM_SRC > (1 << CODE_W)) begin : g_bad_src
      $error("more sources than the source code can name");
   end

   logic [SAMPLE_W-1:0] pick;
   logic                code_ok;

   always_comb begin
      pick    = '0;
      code_ok = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (field.code == CODE_W'(s)) begin
            pick    = srcs[s*SAMPLE_W +: SAMPLE_W];
            code_ok = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         en   <= 1'b0;
         err  <= 1'b0;
      end else if (stb) begin
         en   <= field.en;
         err  <= field.en && !code_ok;
         data <= (field.en && code_ok) ? pick : '0;
      end
   end

   // R6
   lane_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !field.en) |=> (data == '0) && !en && !err);

   // R8
   lane_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && field.en && (int'(field.code) >= NUM_SRC)) |=> err && en && (data == '0));

   // R9
   lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(data) && $stable(en) && $stable(err));
endmodule

// File: rtl/tx_dac_router.sv
module tx_dac_router
   import tx_route_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int NUM_CHAN = 2,
   parameter int NUM_DAC  = 4,
   parameter int CFG_W    = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [CFG_W-1:0]             cfg_wdata,
   output logic [CFG_W-1:0]             cfg_rdata,
   input  logic                         smp_stb,
   input  logic [NUM_CHAN*SAMPLE_W-1:0] ch_i,
   input  logic [NUM_CHAN*SAMPLE_W-1:0] ch_q,
   output logic [NUM_DAC*SAMPLE_W-1:0]  dac_data,
   output logic [NUM_DAC-1:0]           dac_en,
   output logic                         route_err
);
   localparam int NUM_SRC = 2 * NUM_CHAN;
   localparam int ROUTE_W = NUM_DAC * FIELD_W;

   if (SAMPLE_W < 1) begin : g_bad_sample
      $error("sample width must be positive");
   end

   logic [ROUTE_W-1:0]          route;
   logic [NUM_SRC*SAMPLE_W-1:0] srcs;
   logic [NUM_DAC-1:0]          lane_err;

   tx_route_cfg #(.CFG_W(CFG_W), .ROUTE_W(ROUTE_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .route (route)
   );

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_src
      assign srcs[(2*c)*SAMPLE_W   +: SAMPLE_W] = ch_i[c*SAMPLE_W +: SAMPLE_W];
      assign srcs[(2*c+1)*SAMPLE_W +: SAMPLE_W] = ch_q[c*SAMPLE_W +: SAMPLE_W];
   end

   for (genvar d = 0; d < NUM_DAC; d++) begin : g_lane
      route_field_t fld;
      assign fld = route[d*FIELD_W +: FIELD_W];

      tx_route_lane #(.SAMPLE_W(SAMPLE_W), .NUM_SRC(NUM_SRC)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .stb   (smp_stb),
         .field (fld),
         .srcs  (srcs),
         .data  (dac_data[d*SAMPLE_W +: SAMPLE_W]),
         .en    (dac_en[d]),
         .err   (lane_err[d])
      );
   end

   assign route_err = |lane_err;

   // R8
   err_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_err |-> (dac_en != '0));
endmodule

// File: tb/tb_tx_dac_router.sv
module tb_tx_dac_router;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        smp_stb = 1'b0;
   logic [31:0] ch_i = '0;
   logic [31:0] ch_q = '0;
   logic [63:0] dac_data;
   logic [3:0]  dac_en;
   logic        route_err;

   int n_total = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tx_dac_router dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .smp_stb(smp_stb), .ch_i(ch_i), .ch_q(ch_q),
      .dac_data(dac_data), .dac_en(dac_en), .route_err(route_err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // expected DAC sample from a 4-bit field
   function automatic logic [15:0] model(input logic [3:0] f, input logic [31:0] i_in,
                                         input logic [31:0] q_in);
      if (!f[3]) return '0;
      case (f[2:0])
         3'd0: return i_in[15:0];
         3'd1: return q_in[15:0];
         3'd2: return i_in[31:16];
         3'd3: return q_in[31:16];
         default: return '0;
      endcase
   endfunction

   task automatic write_cfg(input logic [31:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic strobe(input logic [31:0] i_in, input logic [31:0] q_in);
      @(negedge clk); ch_i = i_in; ch_q = q_in; smp_stb = 1'b1;
      @(negedge clk); smp_stb = 1'b0;
   endtask

   task automatic check_all(input string req, input logic [15:0] cfg,
                            input logic [31:0] i_in, input logic [31:0] q_in);
      logic [63:0] exp_d;
      logic [3:0]  exp_e;
      logic        exp_err;
      exp_err = 1'b0;
      for (int k = 0; k < 4; k++) begin
         exp_d[k*W +: W] = model(cfg[4*k +: 4], i_in, q_in);
         exp_e[k] = cfg[4*k+3];
         if (cfg[4*k+3] && cfg[4*k+2]) exp_err = 1'b1;
      end
      chk({req, " data"}, dac_data, exp_d);
      chk({req, " en"}, 64'(dac_en), 64'(exp_e));
      chk({req, " err"}, 64'(route_err), 64'(exp_err));
   endtask

   localparam logic [31:0] IV = 32'h2222_1111;
   localparam logic [31:0] QV = 32'h4444_3333;

   task automatic t_reset;
      chk("R1 rdata", 64'(cfg_rdata), 64'h0);
      chk("R1 data", dac_data, 64'h0);
      chk("R1 en", 64'(dac_en), 64'h0);
      chk("R1 err", 64'(route_err), 64'h0);
   endtask

   task automatic t_write;
      write_cfg(32'h0000_BA98);
      chk("R2 readback", 64'(cfg_rdata), 64'h0000_BA98);
      @(negedge clk);
      chk("R2 hold", 64'(cfg_rdata), 64'h0000_BA98);
      write_cfg(32'hFFFF_1234);
      chk("R3 upper ignored", 64'(cfg_rdata), 64'h0000_1234);
   endtask

   task automatic t_routing;
      write_cfg(32'h0000_BA98);
      strobe(IV, QV);
      check_all("R4 R5 direct", 16'hBA98, IV, QV);
      write_cfg(32'h0000_89AB);
      strobe(32'hBEEF_CAFE, 32'h1357_9BDF);
      check_all("R4 R5 reversed", 16'h89AB, 32'hBEEF_CAFE, 32'h1357_9BDF);
   endtask

   task automatic t_fanout;
      write_cfg(32'h0000_AAAA);
      strobe(IV, QV);
      check_all("R7 fanout", 16'hAAAA, IV, QV);
      chk("R7 dac3 ch1I", 64'(dac_data[63:48]), 64'h2222);
   endtask

   task automatic t_disable;
      write_cfg(32'h0000_0A08);
      strobe(IV, QV);
      check_all("R6 disable", 16'h0A08, IV, QV);
   endtask

   task automatic t_reserved;
      write_cfg(32'h0000_0C98);
      strobe(IV, QV);
      check_all("R8 reserved", 16'h0C98, IV, QV);
      chk("R8 err set", 64'(route_err), 64'h1);
      write_cfg(32'h0000_7654);
      strobe(IV, QV);
      check_all("R10 reserved disabled", 16'h7654, IV, QV);
      chk("R10 err clear", 64'(route_err), 64'h0);
   endtask

   task automatic t_hold;
      write_cfg(32'h0000_BA98);
      strobe(IV, QV);
      @(negedge clk); ch_i = 32'hFFFF_FFFF; ch_q = 32'hEEEE_EEEE;
      @(negedge clk);
      check_all("R9 inputs held", 16'hBA98, IV, QV);
      write_cfg(32'h0000_0000);
      @(negedge clk);
      check_all("R9 cfg held", 16'hBA98, IV, QV);
      strobe(32'h5555_6666, 32'h7777_8888);
      check_all("R9 next strobe", 16'h0000, 32'h5555_6666, 32'h7777_8888);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_write;
      t_routing;
      t_fanout;
      t_disable;
      t_reserved;
      t_hold;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule